// File: doc/BRIEF.md
# Pulse-Width Bit Transmitter

This block sends single data bits onto an open-drain, wired-AND serial line. In pulse-width mode every bit period opens with the line pulled low. The line is then let go, and the length of the low phase carries the bit value. Two programmable low-phase counts set the low phase, one for a logical 1 and one for a logical 0. A third input gives the total length of the bit period in clocks. In the non-return-to-zero mode the low-phase counts play no part: a 0 holds the line low for the whole period and a 1 leaves it released.

Bits arrive through a valid/ready handshake. The timing inputs are captured when a bit is accepted from idle and are kept for as long as the block stays busy. A back-to-back stream is accepted in the last clock of each period, so consecutive bits follow with no idle clock between them. Settings that are out of range raise a configuration error, and while that error is present no transmission starts.

Top module: `pwm_bit_tx`

## Requirements
- R1: After reset the block is idle: busy=0, bus_drive_low=0 (line released). bit_ready=1 whenever the block is idle and config_error=0.
- R2: In pulse-width mode (line_mode=0), a bit with bit_data=1 pulls the line (bus_drive_low=1) for low1_cnt+1 clocks from the first clock of the period, then releases it. Values 0 and 399 give 1 and 400 low clocks.
- R3: In pulse-width mode, a bit with bit_data=0 pulls the line for low0_cnt+1 clocks from the first clock of the period, then releases it.
- R4: Each bit period lasts exactly bit_clks clocks. The line stays released from the end of the low phase to the end of the period, and a lone bit keeps busy high for exactly bit_clks clocks.
- R5: config_error=1 when bit_clks<401, or when line_mode=0 and low1_cnt or low0_cnt exceeds 399. While config_error=1 and the block is idle, bit_ready=0 and no bit is accepted (busy stays 0, the line stays released).
- R6: In NRZ mode (line_mode=1), a 0 pulls the line for the whole period and a 1 leaves it released for the whole period. The low counts are ignored and do not raise config_error.
- R7: A bit is accepted on a clock edge where bit_valid=1 and bit_ready=1. While busy, bit_ready is high only in the final clock of the current period. A bit accepted there starts its period on the next clock, with no gap.
- R8: line_mode, low1_cnt, low0_cnt and bit_clks are sampled only when a bit is accepted while busy=0. Changes to them while busy have no effect on the bits in progress.
- R9: busy rises in the clock after the first bit is accepted and falls after the final clock of the last period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| line_mode | input | 1 | 0 = pulse-width coding, 1 = NRZ |
| low1_cnt | input | LOW_W (9) | Low-phase length minus one for a logical 1 |
| low0_cnt | input | LOW_W (9) | Low-phase length minus one for a logical 0 |
| bit_clks | input | PER_W (16) | Bit period length in clocks, at least 401 |
| bit_valid | input | 1 | A bit is offered |
| bit_data | input | 1 | Value of the offered bit |
| bit_ready | output | 1 | The offered bit can be taken on this edge |
| busy | output | 1 | A bit period is in progress |
| bus_drive_low | output | 1 | 1 pulls the open-drain line low, 0 releases it |
| config_error | output | 1 | Current timing inputs are out of range |

## Verification
Both bit values are sent in pulse-width mode across a sweep of low counts, including 0, 1, small values and the 398/399 edge. The 0 and 1 counts are always set to different values, so a swapped selection or an off-by-one low phase shows up in the measured low length. The sweep is repeated at a longer period to separate period timing from the minimum period. NRZ bits with out-of-range counts show that the counts are ignored in that mode. A two-bit stream checks the gapless hand-over and that ready pulses once per period. Out-of-range counts and a short period check that transmission is refused, and settings changed in the middle of a period check the capture at acceptance.

// File: rtl/pwm_tx_pkg.sv
package pwm_tx_pkg;
  typedef enum logic {
    MODE_PWM = 1'b0,
    MODE_NRZ = 1'b1
  } line_mode_e;

  localparam int LOW_W_DEF   = 9;
  localparam int PER_W_DEF   = 16;
  localparam int MAX_LOW_DEF = 399;
endpackage

// File: rtl/pwm_cfg_check.sv
module pwm_cfg_check #(
  parameter int LOW_W   = pwm_tx_pkg::LOW_W_DEF,
  parameter int PER_W   = pwm_tx_pkg::PER_W_DEF,
  parameter int MAX_LOW = pwm_tx_pkg::MAX_LOW_DEF
) (
  input  pwm_tx_pkg::line_mode_e mode,
  input  logic [LOW_W-1:0]       low1,
  input  logic [LOW_W-1:0]       low0,
  input  logic [PER_W-1:0]       per,
  output logic                   bad
);
  localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(MAX_LOW);
  localparam logic [PER_W-1:0] PER_MIN = PER_W'(MAX_LOW + 2);

  logic low_bad;
  logic per_bad;

  always_comb begin
    low_bad = (low1 > LOW_LIM) || (low0 > LOW_LIM);
    per_bad = (per < PER_MIN);
    bad     = per_bad || ((mode == pwm_tx_pkg::MODE_PWM) && low_bad);
  end
endmodule

// File: rtl/pwm_bit_timer.sv
module pwm_bit_timer #(
  parameter int PER_W = pwm_tx_pkg::PER_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [PER_W-1:0] per_q,
  output logic             busy,
  output logic [PER_W-1:0] cnt,
  output logic             last
);
  logic             busy_d;
  logic [PER_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    last   = busy && (cnt == per_q - PER_W'(1));
    busy_d = busy;
    cnt_d  = cnt;
    cnt_en = 1'b0;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else if (last) begin
      busy_d = 1'b0;
    end else if (busy) begin
      cnt_d  = cnt + PER_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
    end else begin
      busy <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (cnt_en) begin
      cnt <= cnt_d;
    end
  end

  // R4: the position inside a period never reaches the period length
  p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt < per_q));

  // R7: a bit taken in the final clock starts at position zero with no idle clock
  p_gapless_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last && accept) |=> (busy && cnt == '0));
endmodule

// File: rtl/pwm_line_enc.sv
module pwm_line_enc #(
  parameter int LOW_W = pwm_tx_pkg::LOW_W_DEF,
  parameter int PER_W = pwm_tx_pkg::PER_W_DEF
) (
  input  logic                   busy,
  input  pwm_tx_pkg::line_mode_e mode,
  input  logic                   bit_val,
  input  logic [LOW_W-1:0]       low1,
  input  logic [LOW_W-1:0]       low0,
  input  logic [PER_W-1:0]       cnt,
  output logic                   drive_low
);
  logic [LOW_W-1:0] low_sel;
  logic             in_low;

  always_comb begin
    low_sel = bit_val ? low1 : low0;
    in_low  = (cnt <= PER_W'(low_sel));
    if (!busy) begin
      drive_low = 1'b0;
    end else if (mode == pwm_tx_pkg::MODE_NRZ) begin
      drive_low = ~bit_val;
    end else begin
      drive_low = in_low;
    end
  end
endmodule

// File: rtl/pwm_bit_tx.sv
module pwm_bit_tx #(
  parameter int LOW_W   = pwm_tx_pkg::LOW_W_DEF,
  parameter int PER_W   = pwm_tx_pkg::PER_W_DEF,
  parameter int MAX_LOW = pwm_tx_pkg::MAX_LOW_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_mode,
  input  logic [LOW_W-1:0] low1_cnt,
  input  logic [LOW_W-1:0] low0_cnt,
  input  logic [PER_W-1:0] bit_clks,
  input  logic             bit_valid,
  input  logic             bit_data,
  output logic             bit_ready,
  output logic             busy,
  output logic             bus_drive_low,
  output logic             config_error
);
  import pwm_tx_pkg::*;

  logic [1:0]       rst_sync;
  logic             rst_q_n;
  logic             cfg_bad;
  logic             accept;
  logic             cap_en;
  logic             last;
  logic [PER_W-1:0] cnt;
  line_mode_e       mode_in;
  line_mode_e       mode_q;
  logic [LOW_W-1:0] low1_q;
  logic [LOW_W-1:0] low0_q;
  logic [PER_W-1:0] per_q;
  logic             bit_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_q_n = rst_sync[1];

  assign mode_in = line_mode_e'(line_mode);

  pwm_cfg_check #(.LOW_W(LOW_W), .PER_W(PER_W), .MAX_LOW(MAX_LOW)) u_chk (
    .mode (mode_in),
    .low1 (low1_cnt),
    .low0 (low0_cnt),
    .per  (bit_clks),
    .bad  (cfg_bad)
  );

  always_comb begin
    bit_ready    = busy ? last : ~cfg_bad;
    accept       = bit_valid && bit_ready;
    cap_en       = accept && !busy;
    config_error = cfg_bad;
  end

  // timing settings: loaded only on a start from idle
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      mode_q <= MODE_PWM;
      low1_q <= '0;
      low0_q <= '0;
      per_q  <= PER_W'(MAX_LOW + 2);
    end else if (cap_en) begin
      mode_q <= mode_in;
      low1_q <= low1_cnt;
      low0_q <= low0_cnt;
      per_q  <= bit_clks;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      bit_q <= 1'b0;
    end else if (accept) begin
      bit_q <= bit_data;
    end
  end

  pwm_bit_timer #(.PER_W(PER_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .accept (accept),
    .per_q  (per_q),
    .busy   (busy),
    .cnt    (cnt),
    .last   (last)
  );

  pwm_line_enc #(.LOW_W(LOW_W), .PER_W(PER_W)) u_enc (
    .busy      (busy),
    .mode      (mode_q),
    .bit_val   (bit_q),
    .low1      (low1_q),
    .low0      (low0_q),
    .cnt       (cnt),
    .drive_low (bus_drive_low)
  );

  // R1: an idle block never pulls the line
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy |-> !bus_drive_low);

  // R5: a bad setting seen while idle keeps the block idle
  p_error_blocks_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!busy && config_error) |=> !busy);

  // R8: captured settings hold through a busy stretch
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && $past(busy)) |-> ($stable(per_q) && $stable(low1_q) &&
                               $stable(low0_q) && $stable(mode_q)));

  // R2: a pulse-width period opens with the line pulled low
  p_pwm_opens_low_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    ($rose(busy) && mode_q == MODE_PWM) |-> bus_drive_low);
endmodule

// File: tb/pwm_bit_tx_test.sv
`timescale 1ns/1ps
module pwm_bit_tx_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        line_mode;
  logic [8:0]  low1_cnt;
  logic [8:0]  low0_cnt;
  logic [15:0] bit_clks;
  logic        bit_valid;
  logic        bit_data;
  logic        bit_ready;
  logic        busy;
  logic        bus_drive_low;
  logic        config_error;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  pwm_bit_tx uut (
    .clk(clk), .rst_n(rst_n), .line_mode(line_mode),
    .low1_cnt(low1_cnt), .low0_cnt(low0_cnt), .bit_clks(bit_clks),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .busy(busy), .bus_drive_low(bus_drive_low), .config_error(config_error)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 200000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 200000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // send one lone bit; measure the low phase, its continuity and the period
  task automatic send_one(input logic b, input int exp_low, input int exp_per,
                          input string tag);
    int lows = 0;
    int per = 0;
    int late_low = 0;
    logic released = 1'b0;
    @(negedge clk);
    chk(bit_ready, 1, {tag, " R7 ready idle"});
    bit_valid = 1'b1; bit_data = b;
    @(negedge clk);
    bit_valid = 1'b0;
    chk(busy, 1, {tag, " R9 busy rises"});
    while (busy && per < 5000) begin
      per++;
      if (bus_drive_low) begin
        if (released) late_low++;
        else lows++;
      end else begin
        released = 1'b1;
      end
      @(negedge clk);
    end
    chk(lows, exp_low, {tag, " low length"});
    chk(late_low, 0, {tag, " R4 released after low"});
    chk(per, exp_per, {tag, " R4 period"});
  endtask

  task automatic set_cfg(input logic m, input int l1, input int l0, input int p);
    line_mode = m; low1_cnt = 9'(l1); low0_cnt = 9'(l0); bit_clks = 16'(p);
  endtask

  initial begin
    int lv[6] = '{0, 1, 2, 7, 398, 399};
    rst_n = 1'b0; bit_valid = 1'b0; bit_data = 1'b0;
    set_cfg(1'b0, 3, 7, 401);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(busy, 0, "R1 busy");
    chk(bus_drive_low, 0, "R1 line released");
    chk(bit_ready, 1, "R1 ready");
    chk(config_error, 0, "R1 no error");

    // R2 / R3 sweep of low counts, 0 and 1 counts differ
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 6; i++) begin
        int per = (p == 0) ? 401 : 420;
        set_cfg(1'b0, lv[i], 399 - lv[i], per);
        send_one(1'b1, lv[i] + 1, per, "R2 one");
        send_one(1'b0, 399 - lv[i] + 1, per, "R3 zero");
      end
    end

    // R6 NRZ, counts out of range are ignored
    set_cfg(1'b1, 450, 500, 401);
    @(negedge clk);
    chk(config_error, 0, "R6 counts ignored");
    send_one(1'b0, 401, 401, "R6 nrz zero");
    send_one(1'b1, 0, 401, "R6 nrz one");

    // R5 out-of-range settings refuse to start
    for (int k = 0; k < 3; k++) begin
      int hits = 0;
      if (k == 0) set_cfg(1'b0, 400, 3, 401);
      else if (k == 1) set_cfg(1'b0, 3, 400, 401);
      else set_cfg(1'b1, 3, 3, 400);
      @(negedge clk);
      chk(config_error, 1, "R5 error flag");
      chk(bit_ready, 0, "R5 ready low");
      bit_valid = 1'b1; bit_data = 1'b0;
      repeat (5) begin
        @(negedge clk);
        if (busy || bus_drive_low) hits++;
      end
      bit_valid = 1'b0;
      chk(hits, 0, "R5 no start");
    end

    // R8 settings changed mid-period
    set_cfg(1'b0, 5, 9, 401);
    @(negedge clk);
    bit_valid = 1'b1; bit_data = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
    begin
      int lows = 1;
      int per = 1;
      @(negedge clk);
      set_cfg(1'b1, 50, 60, 450);
      while (busy && per < 5000) begin
        per++;
        if (bus_drive_low) lows++;
        @(negedge clk);
      end
      chk(lows, 6, "R8 low held");
      chk(per, 401, "R8 period held");
    end

    // R7 back-to-back stream of two bits
    set_cfg(1'b0, 3, 7, 401);
    @(negedge clk);
    bit_valid = 1'b1; bit_data = 1'b1;
    @(negedge clk);
    bit_data = 1'b0;
    begin
      int lows = 0;
      int per = 0;
      int rd = 0;
      int start2 = 0;
      while (busy && per < 5000) begin
        if (per == 401) start2 = bus_drive_low;
        per++;
        if (bus_drive_low) lows++;
        if (bit_ready) rd++;
        @(negedge clk);
        if (rd >= 1) bit_valid = 1'b0;
      end
      chk(per, 802, "R7 gapless two periods");
      chk(lows, 12, "R7 both low phases");
      chk(rd, 2, "R7 ready once per period");
      chk(start2, 1, "R7 second bit starts low");
      chk(busy, 0, "R9 busy falls");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule